// File: doc/BRIEF.md
# Thermal Clock-Throttling Duty Generator

This block cools the system passively by pulling an active-low stop-clock request to the processor for part of every throttle period. Each period starts with the request going low. The block then waits for the processor's stop-grant acknowledge. From that acknowledge it holds the request low for a number of clocks set by a 3-bit duty code. After that it releases the request for the rest of the period.

Throttling can come from three sources. The first is a thermal sensor level that has stayed active for a qualification time while the system is fully running. The second is a software force bit, which acts as if the qualification had already elapsed. The third is a software throttle enable with its own duty code. The thermal duty code wins over the software code whenever the thermal source or the force bit is active. When no source is active, the output returns high at once.

Top module: `thermal_throttle`

## Requirements
- R1: Thermal throttling is only requested after `therm_active` has been high for `QUAL_TICKS` pulses of `slow_tick` in a row. Any low cycle on `therm_active` restarts that count from zero.
- R2: A qualified thermal input requests throttling only when `sys_awake` is 1 and `cpu_cstate` is 2'b00 (C0). The encodings 2'b01, 2'b10 and 2'b11 stand for C1, C2 and C3, and a thermal input in any of these states, or while asleep (`sys_awake` = 0), produces no throttling.
- R3: Once `stop_grant` is seen, `stop_clk_n` stays low for exactly code × `PERIOD_CLKS`/8 further clocks. The code is the 3-bit binary duty value, so 3'b001 gives 1/8 and 3'b111 gives 7/8.
- R4: After `stop_clk_n` falls, no active time is counted until `stop_grant` is high. Until then the output stays low for as long as it takes.
- R5: After the active time, `stop_clk_n` is high for `PERIOD_CLKS` − code × `PERIOD_CLKS`/8 clocks. A grant that is already high therefore gives a low run of code × `PERIOD_CLKS`/8 + 1 samples.
- R6: When the thermal source or `force_throttle` is active, `therm_duty` is used, even if `sw_throttle_en` is also set. `sw_duty` is used only when `sw_throttle_en` is the sole source.
- R7: `force_throttle` starts throttling with `therm_duty` immediately. It needs neither the qualification nor the run-state condition.
- R8: A selected duty code of 3'b000 produces no throttling: `stop_clk_n` stays high.
- R9: A duty code is latched when a period begins. A code changed during a period takes effect only from the next period.
- R10: When no source remains active, `stop_clk_n` is high within two clocks. Clearing `force_throttle` does not stop throttling while `sw_throttle_en` or a qualified thermal input is still active.
- R11: After reset, `stop_clk_n` is high and the qualification count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse of the slow qualification time base |
| therm_active | input | 1 | Thermal sensor over-threshold level, active high |
| sys_awake | input | 1 | 1 when the system is in its working (non-sleep) state |
| cpu_cstate | input | 2 | Processor C-state: 0=C0, 1=C1, 2=C2, 3=C3 |
| force_throttle | input | 1 | Software force of thermal-duty throttling |
| sw_throttle_en | input | 1 | Software-requested throttling enable |
| therm_duty | input | 3 | Duty code for thermal or forced throttling |
| sw_duty | input | 3 | Duty code for software throttling |
| stop_grant | input | 1 | Processor acknowledge of the stop request |
| stop_clk_n | output | 1 | Active-low stop-clock request |

## Verification
The bench builds the block with `PERIOD_CLKS` = 64 and `QUAL_TICKS` = 4. This gives an 8-clock duty step, so every duty code, a full period and the period boundary can be measured in a few dozen cycles. The qualification edge, including a restart after a short drop of the thermal input, is reached after four hand-placed ticks. Holding off the grant beyond a whole period shows that no active time is counted while the block waits. The gating, priority and code-latching cases all fit easily in the cycle budget.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2,
    ST_OFF  = 2'd3
  } thr_state_e;

  localparam logic [1:0] CSTATE_RUN = 2'b00;

  // clocks the stop request is held after the grant
  function automatic int on_clks(input int code, input int step);
    return code * step;
  endfunction

  // clocks the stop request is released in one period
  function automatic int off_clks(input int code, input int step, input int period);
    return period - code * step;
  endfunction

endpackage

// File: rtl/thr_qual_timer.sv
module thr_qual_timer #(
  parameter int QUAL_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic therm_active,
  output logic therm_qual
);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_TICKS);

  logic [QW-1:0] qual_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_cnt <= '0;
    end else if (!therm_active) begin
      qual_cnt <= '0;
    end else if (slow_tick && (qual_cnt != QMAX)) begin
      qual_cnt <= qual_cnt + 1'b1;
    end
  end

  assign therm_qual = (qual_cnt == QMAX);
endmodule

// File: rtl/thr_duty_sel.sv
module thr_duty_sel #(
  parameter int CODE_W = 3
) (
  input  logic              therm_qual,
  input  logic              sys_awake,
  input  logic [1:0]        cpu_cstate,
  input  logic              force_throttle,
  input  logic              sw_throttle_en,
  input  logic [CODE_W-1:0] therm_duty,
  input  logic [CODE_W-1:0] sw_duty,
  output logic              therm_req,
  output logic              req_on,
  output logic [CODE_W-1:0] sel_code
);
  import thr_pkg::*;

  logic run_ok;
  logic therm_path;

  always_comb begin
    run_ok     = sys_awake && (cpu_cstate == CSTATE_RUN);
    therm_req  = therm_qual && run_ok;
    therm_path = therm_req || force_throttle;
    req_on     = therm_path || sw_throttle_en;
    sel_code   = therm_path ? therm_duty : sw_duty;
  end
endmodule

// File: rtl/thr_period_engine.sv
module thr_period_engine #(
  parameter int PERIOD_CLKS = 1024,
  parameter int CODE_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              stop_grant,
  output logic              stop_clk_n,
  output logic              in_wait,
  output logic              in_on,
  output logic              load_code,
  output logic [CODE_W-1:0] cur_code
);
  import thr_pkg::*;

  localparam int CNT_W = $clog2(PERIOD_CLKS);
  localparam int STEP  = PERIOD_CLKS / (2 ** CODE_W);

  thr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             go;
  logic             last_on;
  logic             last_off;

  always_comb begin
    go        = req_on && (sel_code != '0);
    last_on   = (int'(cnt) == on_clks(int'(cur_code), STEP) - 1);
    last_off  = (int'(cnt) == off_clks(int'(cur_code), STEP, PERIOD_CLKS) - 1);
    load_code = go && ((state == ST_IDLE) || ((state == ST_OFF) && last_off));
    in_wait   = (state == ST_WAIT);
    in_on     = (state == ST_ON);
    stop_clk_n = !(in_wait || in_on);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cur_code <= '0;
    end else begin
      if (load_code) cur_code <= sel_code;
      if (state == ST_IDLE) begin
        if (go) begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
      end else if (!req_on) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_WAIT: begin
            if (stop_grant) begin
              state <= ST_ON;
              cnt   <= '0;
            end
          end
          ST_ON: begin
            if (last_on) begin
              state <= ST_OFF;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_OFF: begin
            if (last_off) begin
              state <= go ? ST_WAIT : ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle #(
  parameter int PERIOD_CLKS = 1024,
  parameter int QUAL_TICKS  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       therm_active,
  input  logic       sys_awake,
  input  logic [1:0] cpu_cstate,
  input  logic       force_throttle,
  input  logic       sw_throttle_en,
  input  logic [2:0] therm_duty,
  input  logic [2:0] sw_duty,
  input  logic       stop_grant,
  output logic       stop_clk_n
);
  localparam int CODE_W = 3;
  localparam int STEP_CLKS = PERIOD_CLKS / (2 ** CODE_W);

  logic              therm_qual;
  logic              therm_req;
  logic              req_on;
  logic [CODE_W-1:0] sel_code;
  logic [CODE_W-1:0] cur_code;
  logic              in_wait;
  logic              in_on;
  logic              load_code;

  thr_qual_timer #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .therm_active(therm_active), .therm_qual(therm_qual)
  );

  thr_duty_sel #(.CODE_W(CODE_W)) u_sel (
    .therm_qual(therm_qual), .sys_awake(sys_awake), .cpu_cstate(cpu_cstate),
    .force_throttle(force_throttle), .sw_throttle_en(sw_throttle_en),
    .therm_duty(therm_duty), .sw_duty(sw_duty),
    .therm_req(therm_req), .req_on(req_on), .sel_code(sel_code)
  );

  thr_period_engine #(.PERIOD_CLKS(PERIOD_CLKS), .CODE_W(CODE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .sel_code(sel_code),
    .stop_grant(stop_grant), .stop_clk_n(stop_clk_n),
    .in_wait(in_wait), .in_on(in_on), .load_code(load_code),
    .cur_code(cur_code)
  );
endmodule

// File: rtl/thermal_throttle_chk.sv
module thermal_throttle_chk #(
  parameter int STEP = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic       therm_active,
  input logic       sys_awake,
  input logic [1:0] cpu_cstate,
  input logic       force_throttle,
  input logic       sw_throttle_en,
  input logic       stop_grant,
  input logic       stop_clk_n,
  input logic       therm_qual,
  input logic       req_on,
  input logic       in_wait,
  input logic       in_on,
  input logic       load_code,
  input logic [2:0] cur_code
);
  int on_run;

  always_ff @(posedge clk) begin
    if (!rst_n) on_run <= 0;
    else if (in_on) on_run <= on_run + 1;
    else on_run <= 0;
  end

  assert_qual_tracks_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    therm_qual |-> $past(therm_active));

  assert_gated_out_of_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_throttle && !sw_throttle_en && !(sys_awake && cpu_cstate == 2'b00)) |-> !req_on);

  assert_on_time_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_on |-> (on_run < int'(cur_code) * STEP));

  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !stop_grant && req_on) |=> (in_wait && !stop_clk_n));

  assert_zero_code_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (cur_code != 3'd0));

  assert_code_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_code |=> $stable(cur_code));

  assert_release_without_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_on |=> stop_clk_n);
endmodule

bind thermal_throttle thermal_throttle_chk #(.STEP(STEP_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .therm_active(therm_active), .sys_awake(sys_awake),
  .cpu_cstate(cpu_cstate), .force_throttle(force_throttle),
  .sw_throttle_en(sw_throttle_en), .stop_grant(stop_grant),
  .stop_clk_n(stop_clk_n), .therm_qual(therm_qual), .req_on(req_on),
  .in_wait(in_wait), .in_on(in_on), .load_code(load_code), .cur_code(cur_code)
);

// File: tb/test_thermal_throttle.sv
module test_thermal_throttle;
  localparam int P    = 64;
  localparam int QT   = 4;
  localparam int STEP = P / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0;
  logic therm_active = 1'b0;
  logic sys_awake = 1'b1;
  logic [1:0] cpu_cstate = 2'b00;
  logic force_throttle = 1'b0;
  logic sw_throttle_en = 1'b0;
  logic [2:0] therm_duty = 3'd0;
  logic [2:0] sw_duty = 3'd0;
  logic stop_grant = 1'b1;
  logic stop_clk_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  thermal_throttle #(.PERIOD_CLKS(P), .QUAL_TICKS(QT)) i_thermal_throttle (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .therm_active(therm_active),
    .sys_awake(sys_awake), .cpu_cstate(cpu_cstate), .force_throttle(force_throttle),
    .sw_throttle_en(sw_throttle_en), .therm_duty(therm_duty), .sw_duty(sw_duty),
    .stop_grant(stop_grant), .stop_clk_n(stop_clk_n)
  );

  typedef struct packed {
    logic [2:0] td;
    logic [2:0] sd;
    logic       frc;
    logic       swe;
    logic [2:0] exp_code;
  } vec_t;

  // stimulus: thermal code, software code, force, sw enable, code expected in use
  localparam vec_t VECS [5] = '{
    '{3'd1, 3'd0, 1'b1, 1'b0, 3'd1},
    '{3'd7, 3'd0, 1'b1, 1'b0, 3'd7},
    '{3'd0, 3'd3, 1'b0, 1'b1, 3'd3},
    '{3'd2, 3'd6, 1'b1, 1'b1, 3'd2},
    '{3'd1, 3'd5, 1'b0, 1'b1, 3'd5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_once();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    @(negedge clk);
  endtask

  // waits for the next falling edge of the stop request, then counts its low and high run
  task automatic measure(output int lo, output int hi);
    int guard;
    lo = 0; hi = 0; guard = 0;
    while (stop_clk_n !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
    while (stop_clk_n !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    while (stop_clk_n === 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
    while (stop_clk_n === 1'b1 && guard < 4000) begin hi++; @(negedge clk); guard++; end
  endtask

  task automatic quiet();
    force_throttle = 1'b0;
    sw_throttle_en = 1'b0;
    therm_active = 1'b0;
    therm_duty = 3'd0;
    sw_duty = 3'd0;
    cycles(3);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lo, hi, n, guard;
    bit seen;
    cycles(3);
    // R11: reset state
    check(stop_clk_n === 1'b1, "R11 reset output", int'(stop_clk_n), 1);
    rst_n = 1'b1;
    cycles(2);
    check(stop_clk_n === 1'b1, "R11 after reset release", int'(stop_clk_n), 1);

    // table walk: R3 R5 R6 R7 R10
    foreach (VECS[k]) begin
      therm_duty = VECS[k].td;
      sw_duty = VECS[k].sd;
      force_throttle = VECS[k].frc;
      sw_throttle_en = VECS[k].swe;
      measure(lo, hi);
      check(lo == int'(VECS[k].exp_code) * STEP + 1, "R3/R6 low run", lo,
            int'(VECS[k].exp_code) * STEP + 1);
      check(hi == P - int'(VECS[k].exp_code) * STEP, "R5 high run", hi,
            P - int'(VECS[k].exp_code) * STEP);
      quiet();
      check(stop_clk_n === 1'b1, "R10 release", int'(stop_clk_n), 1);
    end

    // R1: qualification count and restart
    therm_duty = 3'd3;
    therm_active = 1'b1;
    tick_once(); tick_once(); tick_once();
    cycles(4);
    check(stop_clk_n === 1'b1, "R1 three ticks not enough", int'(stop_clk_n), 1);
    therm_active = 1'b0;
    @(negedge clk);
    therm_active = 1'b1;
    tick_once(); tick_once(); tick_once();
    cycles(4);
    check(stop_clk_n === 1'b1, "R1 drop restarts count", int'(stop_clk_n), 1);
    tick_once();
    @(negedge clk);
    check(stop_clk_n === 1'b0, "R1 qualified throttle", int'(stop_clk_n), 0);
    measure(lo, hi);
    check(lo == 3 * STEP + 1, "R1 thermal low run", lo, 3 * STEP + 1);
    // R10: thermal drop ends throttling within two clocks
    therm_active = 1'b0;
    cycles(2);
    check(stop_clk_n === 1'b1, "R10 thermal drop", int'(stop_clk_n), 1);

    // R2: qualified thermal input in C2 and while asleep
    cpu_cstate = 2'b10;
    therm_active = 1'b1;
    for (int i = 0; i < QT + 1; i++) tick_once();
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (stop_clk_n !== 1'b1) seen = 1'b1; end
    check(!seen, "R2 no throttle in C2", int'(seen), 0);
    cpu_cstate = 2'b00;
    sys_awake = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (stop_clk_n !== 1'b1) seen = 1'b1; end
    check(!seen, "R2 no throttle asleep", int'(seen), 0);
    sys_awake = 1'b1;
    cycles(2);
    check(stop_clk_n === 1'b0, "R2 throttle in C0", int'(stop_clk_n), 0);
    quiet();

    // R7: force bypasses qualification and run-state gating
    sys_awake = 1'b0;
    therm_duty = 3'd3;
    force_throttle = 1'b1;
    measure(lo, hi);
    check(lo == 3 * STEP + 1, "R7 forced low run", lo, 3 * STEP + 1);
    quiet();
    sys_awake = 1'b1;

    // R8: zero code never throttles
    force_throttle = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 2 * P; i++) begin @(negedge clk); if (stop_clk_n !== 1'b1) seen = 1'b1; end
    check(!seen, "R8 code zero", int'(seen), 0);
    quiet();

    // R4: no counting before grant
    stop_grant = 1'b0;
    therm_duty = 3'd2;
    force_throttle = 1'b1;
    cycles(2);
    seen = 1'b0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (stop_clk_n !== 1'b0) seen = 1'b1; end
    check(!seen, "R4 held low without grant", int'(seen), 0);
    stop_grant = 1'b1;
    n = 0; guard = 0;
    @(negedge clk);
    while (stop_clk_n === 1'b0 && guard < 500) begin n++; @(negedge clk); guard++; end
    check(n == 2 * STEP, "R4 count from grant", n, 2 * STEP);
    n = 0;
    while (stop_clk_n === 1'b1 && guard < 500) begin n++; @(negedge clk); guard++; end
    check(n == P - 2 * STEP, "R5 off time", n, P - 2 * STEP);
    quiet();

    // R9: code change mid-period waits for the boundary
    therm_duty = 3'd1;
    force_throttle = 1'b1;
    guard = 0;
    while (stop_clk_n !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
    therm_duty = 3'd7;
    n = 0;
    while (stop_clk_n === 1'b0 && guard < 500) begin n++; @(negedge clk); guard++; end
    check(n == STEP + 1, "R9 old code kept", n, STEP + 1);
    measure(lo, hi);
    check(lo == 7 * STEP + 1, "R9 new code next period", lo, 7 * STEP + 1);

    // R10: clearing force while software throttling stays on
    sw_throttle_en = 1'b1;
    sw_duty = 3'd2;
    force_throttle = 1'b0;
    measure(lo, hi);
    check(lo == 2 * STEP + 1, "R10 software continues", lo, 2 * STEP + 1);
    sw_throttle_en = 1'b0;
    @(negedge clk);
    check(stop_clk_n === 1'b1, "R10 last source cleared", int'(stop_clk_n), 1);
    quiet();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule